// File: doc/BRIEF.md
# Binary and Packed-BCD Add-With-Carry Unit

This block is the add-with-carry path of an 8-bit processor's arithmetic unit. Each cycle in which the input strobe is high, it takes an accumulator value, a memory operand, the incoming carry flag and a decimal-mode select. On the next clock edge it registers an 8-bit sum and four condition flags: zero, negative, overflow and carry.

In binary mode the sum and flags are those of a plain 8-bit adder. In decimal mode the operands are treated as two packed BCD digits, and the sum is corrected in two stages. The first stage corrects the low digit. The second stage corrects the high digit.

The flags copy the behaviour of early 8-bit processors rather than that of a clean BCD adder:

- Zero is always taken from the uncorrected binary sum.
- In decimal mode, negative and overflow are taken from the value after the low-digit correction only.

Nibbles in the range A to F are not rejected. They go through the same arithmetic, so every input gives a defined output.

Top module: `bcd_adc_unit`

## Requirements
- R1: The raw sum is accumulator plus operand plus carry-in. In binary mode the registered result is its low 8 bits.
- R2: The zero flag is set exactly when the low 8 bits of the raw binary sum are zero, in both modes, before any decimal correction.
- R3: In binary mode, the negative flag is bit 7 of the raw sum, and the carry flag is set when the raw sum exceeds 0xFF.
- R4: In decimal mode, when the low nibble of the accumulator plus the low nibble of the operand plus carry-in exceeds 9, 6 is added to the raw sum to form the intermediate value.
- R5: In decimal mode, the negative flag is bit 7 of the intermediate value from R4.
- R6: The overflow flag is set when accumulator bit 7 equals operand bit 7 and differs from bit 7 of the checked value. In binary mode the checked value is the raw sum. In decimal mode it is the R4 intermediate.
- R7: In decimal mode, when the R4 intermediate exceeds 0x99, 0x60 is added to it, and the carry flag is set exactly when the R4 intermediate exceeds 0x99.
- R8: In decimal mode, the result is the low 8 bits of the value after the R7 correction.
- R9: The result and flags are registered on the clock edge after a cycle with `in_valid` high, and `out_valid` is high in the cycle that follows each strobe. After a cycle with `in_valid` low, `out_valid` is low and the result and flags keep their previous values.
- R10: While `rst_n` is low at a clock edge, the result, all four flags and `out_valid` clear to 0.
- R11: Operands with nibbles A to F in decimal mode are processed by the same rules R4 to R8, without special handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands valid this cycle |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Memory operand |
| carry_in | input | 1 | Incoming carry flag |
| dec_mode | input | 1 | 1 = packed-BCD decimal mode, 0 = binary mode |
| sum_out | output | 8 | Registered result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| out_valid | output | 1 | Result valid, one cycle per strobe |

## Verification
On every cycle, the assertions check the following:

- the output handshake and the hold behaviour;
- the zero flag against the raw sum of the previous inputs;
- the full binary-mode result and carry against the previous inputs.

The decimal corrections, the partly corrected negative and overflow flags, and the handling of nibbles A to F are shown only by the bench. The bench sweeps every combination of accumulator, operand, carry-in and mode and compares each against its behavioural model. Idle gaps with changed inputs show the hold rule, and the reset phase shows the cleared state.

// File: rtl/bcd_adc_pkg.sv
// Shared widths and the flag bundle for the add-with-carry unit.
// Assumes an 8-bit datapath made of two 4-bit BCD digits.
package bcd_adc_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int RAW_W  = DATA_W + 2;   // room for both decimal corrections

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } adc_flags_t;
endpackage

// File: rtl/adc_binary_path.sv
// Binary half of the adder: forms the raw sum and the binary-mode flags.
// Assumes W-bit operands; the raw sum is widened to RAW_W bits.
module adc_binary_path #(
    parameter int W     = 8,
    parameter int RAW_W = W + 2
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     m,
    input  logic             cin,
    output logic [RAW_W-1:0] raw,
    output logic             z,
    output logic             n_bin,
    output logic             v_bin,
    output logic             c_bin
);
    localparam int MSB = W - 1;

    // Raw sum and flags derived from it.
    always_comb begin
        raw   = RAW_W'(a) + RAW_W'(m) + RAW_W'(cin);
        z     = (raw[W-1:0] == '0);
        n_bin = raw[MSB];
        v_bin = ~(a[MSB] ^ m[MSB]) & (a[MSB] ^ raw[MSB]);
        c_bin = |raw[RAW_W-1:W];
    end
endmodule

// File: rtl/adc_decimal_path.sv
// Decimal half: applies the low-digit and high-digit BCD corrections to
// the raw sum and derives negative, overflow and carry from the partly
// corrected intermediate. Assumes W = 2 * NW (two packed digits).
module adc_decimal_path #(
    parameter int W     = 8,
    parameter int NW    = 4,
    parameter int RAW_W = W + 2
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     m,
    input  logic             cin,
    input  logic [RAW_W-1:0] raw,
    output logic [W-1:0]     res_dec,
    output logic             n_dec,
    output logic             v_dec,
    output logic             c_dec
);
    localparam int MSB      = W - 1;
    localparam int LO_W     = NW + 1;
    localparam int DIG_MAX  = 9;
    localparam int LO_FIX   = 6;
    localparam int HI_LIMIT = (DIG_MAX << NW) | DIG_MAX;   // 0x99
    localparam int HI_FIX   = LO_FIX << NW;                // 0x60

    logic [LO_W-1:0]  lo_sum;
    logic [RAW_W-1:0] mid;
    logic [RAW_W-1:0] fin;
    logic             hi_over;

    // Low-digit correction of the raw sum.
    always_comb begin
        lo_sum = LO_W'(a[NW-1:0]) + LO_W'(m[NW-1:0]) + LO_W'(cin);
        mid    = raw + ((lo_sum > LO_W'(DIG_MAX)) ? RAW_W'(LO_FIX) : '0);
    end

    // High-digit correction and the flags taken from the intermediate.
    always_comb begin
        hi_over = (mid > RAW_W'(HI_LIMIT));
        fin     = mid + (hi_over ? RAW_W'(HI_FIX) : '0);
        n_dec   = mid[MSB];
        v_dec   = ~(a[MSB] ^ m[MSB]) & (a[MSB] ^ mid[MSB]);
        c_dec   = hi_over;
        res_dec = fin[W-1:0];
    end
endmodule

// File: rtl/adc_out_reg.sv
// Output register: captures result and flags when the strobe is high,
// holds them otherwise, and raises the valid flag for one cycle per strobe.
// Assumes a synchronous active-low reset.
module adc_out_reg
    import bcd_adc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] res_d,
    input  adc_flags_t   flg_d,
    output logic [W-1:0] res_q,
    output adc_flags_t   flg_q,
    output logic         vld_q
);
    // Capture on strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            flg_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= load;
            if (load) begin
                res_q <= res_d;
                flg_q <= flg_d;
            end
        end
    end

    // R9: a strobe is followed by a valid cycle
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> vld_q);

    // R9: no strobe means the outputs hold and valid stays low
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (!vld_q && $stable(res_q) && $stable(flg_q)));
endmodule

// File: rtl/bcd_adc_unit.sv
// Top of the add-with-carry unit: binary path, decimal path, mode select
// and output register. Assumes operands are stable in the cycle in_valid
// is high; non-BCD nibbles pass through the same arithmetic.
module bcd_adc_unit
    import bcd_adc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              carry_in,
    input  logic              dec_mode,
    output logic [DATA_W-1:0] sum_out,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_v,
    output logic              flag_c,
    output logic              out_valid
);
    logic [RAW_W-1:0]  raw;
    logic              z_raw, n_bin, v_bin, c_bin;
    logic [DATA_W-1:0] res_dec;
    logic              n_dec, v_dec, c_dec;
    logic [DATA_W-1:0] res_sel;
    adc_flags_t        flg_sel, flg_q;

    adc_binary_path #(.W(DATA_W), .RAW_W(RAW_W)) u_bin (
        .a(acc_in), .m(opnd_in), .cin(carry_in), .raw(raw),
        .z(z_raw), .n_bin(n_bin), .v_bin(v_bin), .c_bin(c_bin)
    );

    adc_decimal_path #(.W(DATA_W), .NW(NIB_W), .RAW_W(RAW_W)) u_dec (
        .a(acc_in), .m(opnd_in), .cin(carry_in), .raw(raw),
        .res_dec(res_dec), .n_dec(n_dec), .v_dec(v_dec), .c_dec(c_dec)
    );

    // Mode select; zero always comes from the raw binary sum.
    always_comb begin
        flg_sel.z = z_raw;
        if (dec_mode) begin
            res_sel   = res_dec;
            flg_sel.n = n_dec;
            flg_sel.v = v_dec;
            flg_sel.c = c_dec;
        end else begin
            res_sel   = raw[DATA_W-1:0];
            flg_sel.n = n_bin;
            flg_sel.v = v_bin;
            flg_sel.c = c_bin;
        end
    end

    adc_out_reg #(.W(DATA_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .load(in_valid),
        .res_d(res_sel), .flg_d(flg_sel),
        .res_q(sum_out), .flg_q(flg_q), .vld_q(out_valid)
    );

    // Flag bundle to output pins.
    always_comb begin
        flag_z = flg_q.z;
        flag_n = flg_q.n;
        flag_v = flg_q.v;
        flag_c = flg_q.c;
    end

    // R2: registered zero flag matches the raw sum of the strobed inputs
    a_r2_zero_from_raw: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (flag_z == ((($past(acc_in) + $past(opnd_in)
                                   + DATA_W'($past(carry_in))) & 8'hFF) == 8'h00)));

    // R3: binary mode gives the full 9-bit sum on {carry, result}
    a_r3_binary_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dec_mode) |=>
            ({flag_c, sum_out} == ({1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)}
                                   + 9'($past(carry_in)))));
endmodule

// File: tb/bcd_adc_unit_test.sv
// Exhaustive bench: lane uut sweeps binary mode, lane uut_dec decimal mode,
// both in lockstep, one vector per clock, against a behavioural model.
module bcd_adc_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_VECS  = 1 << 17;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] acc = '0;
    logic [7:0] opnd = '0;
    logic       cin = 1'b0;

    logic [7:0] sum0, sum1;
    logic       z0, n0, v0, c0, ov0;
    logic       z1, n1, v1, c1, ov1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_adc_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .acc_in(acc), .opnd_in(opnd), .carry_in(cin), .dec_mode(1'b0),
        .sum_out(sum0), .flag_z(z0), .flag_n(n0), .flag_v(v0), .flag_c(c0),
        .out_valid(ov0)
    );

    bcd_adc_unit uut_dec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .acc_in(acc), .opnd_in(opnd), .carry_in(cin), .dec_mode(1'b1),
        .sum_out(sum1), .flag_z(z1), .flag_n(n1), .flag_v(v1), .flag_c(c1),
        .out_valid(ov1)
    );

    // Behavioural model, packed as {valid, result[7:0], z, n, v, c}.
    function automatic logic [12:0] model(int a, int m, int ci, int dm);
        int t, lo, res, z, n, v, c;
        t = a + m + ci;
        z = ((t % 256) == 0);
        if (dm != 0) begin
            lo = (a % 16) + (m % 16) + ci;
            if (lo > 9) t = t + 6;              // R4
            n = (t / 128) % 2;                  // R5
            v = (((a / 128) == (m / 128)) && ((a / 128) != ((t / 128) % 2))) ? 1 : 0; // R6
            c = (t > 153) ? 1 : 0;              // R7
            if (t > 153) t = t + 96;            // R7
            res = t % 256;                      // R8
        end else begin
            n = (t / 128) % 2;                  // R3
            v = (((a / 128) == (m / 128)) && ((a / 128) != ((t / 128) % 2))) ? 1 : 0; // R6
            c = (t > 255) ? 1 : 0;              // R3
            res = t % 256;                      // R1
        end
        return {1'b1, 8'(res), 1'(z), 1'(n), 1'(v), 1'(c)};
    endfunction

    task automatic cmp(input string req, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (acc=%h opnd=%h cin=%b)",
                     req, act, exp, acc, opnd, cin);
        end
    endtask

    logic [12:0] exp0, exp1;

    initial begin
        int mark;
        // R10: reset clears everything
        repeat (3) @(negedge clk);
        cmp("R10 bin lane", {ov0, sum0, z0, n0, v0, c0}, 13'h0);
        cmp("R10 dec lane", {ov1, sum1, z1, n1, v1, c1}, 13'h0);
        rst_n = 1'b1;
        exp0 = 13'h0;
        exp1 = 13'h0;
        for (int i = 0; i < HALF_VECS; i++) begin
            acc      = 8'(i >> 9);
            opnd     = 8'(i >> 1);
            cin      = i[0];
            in_valid = 1'b1;
            @(negedge clk);
            exp0 = model(int'(acc), int'(opnd), int'(cin), 0);
            exp1 = model(int'(acc), int'(opnd), int'(cin), 1);
            // R1 R2 R3 R6 R9: binary lane; R4 R5 R6 R7 R8 R11: decimal lane
            cmp("R1/R2/R3/R6/R9 binary", {ov0, sum0, z0, n0, v0, c0}, exp0);
            cmp("R2/R4/R5/R6/R7/R8/R11 decimal", {ov1, sum1, z1, n1, v1, c1}, exp1);
            if ((i % 4096) == 4095) begin
                // R9: idle cycle with changed inputs must not disturb outputs
                in_valid = 1'b0;
                acc      = ~acc;
                opnd     = ~opnd;
                cin      = ~cin;
                @(negedge clk);
                mark = 0;
                cmp("R9 hold binary", {ov0, sum0, z0, n0, v0, c0}, {1'b0, exp0[11:0]});
                cmp("R9 hold decimal", {ov1, sum1, z1, n1, v1, c1}, {1'b0, exp1[11:0]});
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        cmp("R9 valid drop", {ov0, ov1}, 13'h0);
        // R10: reset after activity clears the outputs again
        rst_n = 1'b0;
        @(negedge clk);
        cmp("R10 late reset bin", {ov0, sum0, z0, n0, v0, c0}, 13'h0);
        cmp("R10 late reset dec", {ov1, sum1, z1, n1, v1, c1}, 13'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule